// File: doc/BRIEF.md
# Bus-Snooping Look-Aside Cache

This block is a small cache that hangs off a shared system bus next to memory rather than in front of it. When any bus master opens a cycle to a cacheable address, the cache raises a wait line for one clock. That line holds memory back while the cache compares the address against its tags. On a read hit the cache drives the stored word and terminates the cycle itself on the next clock, so memory never answers. On a read miss, on a write, and on any cycle to an address it does not cover, it lets memory complete the cycle and does not drive the data bus.

The cache learns its contents by watching the bus. A read miss takes the word that memory returns when the cycle ends. A write from any master, whether processor or DMA, is copied into a matching entry. The cache therefore stays consistent with memory without ever being flushed. The organisation is direct-mapped with one word per entry. Two inclusive address windows, a fast-RAM window and an expansion window, are the only cacheable space. A per-master mask selects which masters' read misses may fill entries.

Top module: `snoop_cache`

## Requirements
- R1: After reset every entry is invalid and the first read of any address misses; `bus_wait`, `cache_term` and `cache_oe` are low while no cycle is open.
- R2: A cycle is opened by the clock in which `bus_strobe` is first seen high. When its address lies inside either inclusive window (`FAST_LO`..`FAST_HI` or `EXP_LO`..`EXP_HI`), `bus_wait` is high during exactly that clock and low for the rest of the cycle.
- R3: A cycle to an address outside both windows never raises `bus_wait`, `cache_term` or `cache_oe`. It does not alter any entry.
- R4: On a cacheable read miss the cache does not terminate and does not drive the data bus. When `mem_term` is high, the word on `bus_data` is stored into the entry selected by the low `IDX_W` address bits, tagged with the remaining bits, and the entry is marked valid.
- R5: On a cacheable read hit, `cache_term` and `cache_oe` are high in the clock after the opening clock and for that one clock only. `cache_data` then carries the most recent word written to, or read from memory at, that address.
- R6: On a cacheable write from any master, the cache never terminates or drives the bus. When `mem_term` is high and the entry matches, that entry takes the written word.
- R7: A write that misses allocates nothing: a later read of that address still misses.
- R8: A read miss by a master whose bit in `FILL_MASK` (indexed by `bus_master`) is clear does not fill.
- R9: A fill replaces whatever the indexed entry held, so an address sharing the index with a newer fill misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | AW | Word address of the current cycle |
| bus_data | input | DW | Data on the bus as driven by memory (reads) or by the master (writes) |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_strobe | input | 1 | High for the whole duration of a bus cycle |
| bus_master | input | MID_W | Identity of the master running the cycle |
| mem_term | input | 1 | Memory's cycle-termination signal |
| bus_wait | output | 1 | Intercept line holding memory off during lookup |
| cache_term | output | 1 | Cycle termination driven by the cache on a hit |
| cache_oe | output | 1 | Enable for the cache's data driver |
| cache_data | output | DW | Word supplied on a hit, zero otherwise |

## Verification
The assertions assume that a master holds address, direction and identity steady while `bus_strobe` is high, and that it drops the strobe for at least one clock between cycles. They also assume that memory raises `mem_term` only when the cache has not claimed the cycle. The bench opens every cycle on a falling edge and keeps all bus fields fixed until it releases the strobe. It sends `mem_term` only when the cache has not terminated, and idles one clock after each cycle. A bench-side memory image and a tag model predict every hit, and every hit's data is compared against that image, which checks coherence directly.

// File: rtl/snoop_cache.sv
module snoop_cache #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int IDX_W = 4,
  parameter int MID_W = 2,
  parameter logic [AW-1:0] FAST_LO = 24'h200000,
  parameter logic [AW-1:0] FAST_HI = 24'h9FFFFF,
  parameter logic [AW-1:0] EXP_LO  = 24'hE00000,
  parameter logic [AW-1:0] EXP_HI  = 24'hEFFFFF,
  parameter logic [(1<<MID_W)-1:0] FILL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             bus_wr,
  input  logic             bus_strobe,
  input  logic [MID_W-1:0] bus_master,
  input  logic             mem_term,
  output logic             bus_wait,
  output logic             cache_term,
  output logic             cache_oe,
  output logic [DW-1:0]    cache_data
);
  localparam int N = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_HIT, S_MEM, S_DONE} st_t;
  st_t st;

  logic [N-1:0]     vld;
  logic [TAG_W-1:0] tags [N];
  logic [DW-1:0]    words [N];

  wire [IDX_W-1:0] idx = bus_addr[IDX_W-1:0];
  wire [TAG_W-1:0] tag = bus_addr[AW-1:IDX_W];

  wire cacheable = (bus_addr >= FAST_LO && bus_addr <= FAST_HI) ||
                   (bus_addr >= EXP_LO  && bus_addr <= EXP_HI);
  wire hit   = vld[idx] && tags[idx] == tag;
  wire start = st == S_IDLE && bus_strobe;
  wire fill  = st == S_MEM && mem_term && !bus_wr && FILL_MASK[bus_master];
  wire upd   = st == S_MEM && mem_term && bus_wr && hit;

  assign bus_wait   = start && cacheable;
  assign cache_term = st == S_HIT;
  assign cache_oe   = st == S_HIT;
  assign cache_data = cache_oe ? words[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE: if (bus_strobe)
                  st <= !cacheable ? S_DONE : (hit && !bus_wr) ? S_HIT : S_MEM;
        S_HIT:  st <= S_DONE;
        S_MEM:  if (mem_term) st <= S_DONE;
        default: if (!bus_strobe) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (fill) vld[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tags[idx]  <= tag;
      words[idx] <= bus_data;
    end else if (upd) begin
      words[idx] <= bus_data;
    end
  end
endmodule

module snoop_cache_chk #(
  parameter int AW = 24,
  parameter int MID_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_strobe,
  input logic [MID_W-1:0] bus_master,
  input logic             mem_term,
  input logic             bus_wait,
  input logic             cache_term,
  input logic             cache_oe
);
  assert_wait_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |=> !bus_wait);
  assert_wait_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> bus_strobe);
  assert_fields_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && $past(bus_strobe)) |->
      ($stable(bus_addr) && $stable(bus_wr) && $stable(bus_master)));
  assert_term_follows_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cache_term |-> $past(bus_wait));
  assert_term_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cache_term |=> !cache_term);
  assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_wr) |-> !cache_oe);
  assert_no_double_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cache_term && mem_term));
endmodule

bind snoop_cache snoop_cache_chk #(.AW(AW), .MID_W(MID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_strobe(bus_strobe), .bus_master(bus_master), .mem_term(mem_term),
  .bus_wait(bus_wait), .cache_term(cache_term), .cache_oe(cache_oe)
);

// File: tb/snoop_cache_tb_top.sv
`timescale 1ns/1ps
module snoop_cache_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = '0, bus_data = '0;
  logic bus_wr = 0, bus_strobe = 0, mem_term = 0;
  logic [1:0] bus_master = '0;
  logic bus_wait, cache_term, cache_oe;
  logic [7:0] cache_data;

  always #2.5 clk = ~clk;

  snoop_cache #(.AW(8), .DW(8), .IDX_W(3), .MID_W(2),
    .FAST_LO(8'h20), .FAST_HI(8'h3F), .EXP_LO(8'h80), .EXP_HI(8'h9F),
    .FILL_MASK(4'b0111)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_wr(bus_wr), .bus_strobe(bus_strobe), .bus_master(bus_master),
    .mem_term(mem_term), .bus_wait(bus_wait), .cache_term(cache_term),
    .cache_oe(cache_oe), .cache_data(cache_data));

  int checks = 0, fails = 0;
  logic [7:0] mem_img [256];
  logic       rv [8];
  logic [4:0] rt [8];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit in_win(input logic [7:0] a);
    return (a >= 8'h20 && a <= 8'h3F) || (a >= 8'h80 && a <= 8'h9F);
  endfunction

  task automatic cyc(input logic [7:0] a, input bit wr, input logic [1:0] m,
                     input logic [7:0] wd, output bit got_hit);
    bit c, eh;
    string lbl;
    c  = in_win(a);
    eh = !wr && c && rv[a[2:0]] && rt[a[2:0]] == a[7:3];
    lbl = wr ? "R6" : (!c ? "R3" : (eh ? "R5" : "R4"));
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_master = m; bus_strobe = 1;
    bus_data = wr ? wd : 8'hxx;
    #1;
    check(bus_wait === c, c ? "R2" : "R3", bus_wait, c);
    check(cache_term === 0, lbl, cache_term, 0);
    @(negedge clk);
    check(bus_wait === 0, "R2", bus_wait, 0);
    got_hit = cache_term === 1'b1;
    check(cache_term === eh, lbl, cache_term, eh);
    check(cache_oe === eh, lbl, cache_oe, eh);
    if (eh) check(cache_data === mem_img[a], "R5", cache_data, mem_img[a]);
    if (!got_hit) begin
      mem_term = 1;
      if (!wr) bus_data = mem_img[a];
    end
    @(negedge clk);
    mem_term = 0; bus_strobe = 0;
    check(cache_term === 0 && cache_oe === 0, "R5", {cache_term, cache_oe}, 0);
    if (wr) mem_img[a] = wd;
    else if (c && !eh && m != 2'd3) begin
      rv[a[2:0]] = 1; rt[a[2:0]] = a[7:3];
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit h;
    logic [15:0] lf;
    for (int i = 0; i < 256; i++) mem_img[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 8; i++) begin rv[i] = 0; rt[i] = '0; end
    repeat (3) @(negedge clk);
    check(bus_wait === 0 && cache_term === 0 && cache_oe === 0, "R1",
          {bus_wait, cache_term, cache_oe}, 0);
    rst_n = 1;
    @(negedge clk);

    cyc(8'h21, 0, 0, 0, h); check(h == 0, "R1", h, 0);
    cyc(8'h22, 0, 3, 0, h);
    cyc(8'h22, 0, 0, 0, h); check(h == 0, "R8", h, 0);
    cyc(8'h22, 0, 1, 0, h); check(h == 1, "R4", h, 1);
    cyc(8'h23, 1, 2, 8'hC3, h);
    cyc(8'h23, 0, 0, 0, h); check(h == 0, "R7", h, 0);
    cyc(8'h24, 0, 0, 0, h);
    cyc(8'h2C, 0, 0, 0, h);
    cyc(8'h24, 0, 0, 0, h); check(h == 0, "R9", h, 0);
    cyc(8'h4C, 0, 0, 0, h);
    cyc(8'h24, 0, 0, 0, h); check(h == 1, "R3", h, 1);
    cyc(8'h24, 1, 3, 8'hE7, h);
    cyc(8'h24, 0, 2, 0, h); check(h == 1, "R6", h, 1);
    cyc(8'h1F, 0, 0, 0, h); cyc(8'h40, 0, 0, 0, h);
    cyc(8'h7F, 0, 0, 0, h); cyc(8'hA0, 0, 0, 0, h);

    for (int a = 0; a < 256; a++) begin
      cyc(8'(a), 0, 0, 0, h);
      cyc(8'(a), 0, 1, 0, h);
      check(h == in_win(8'(a)), in_win(8'(a)) ? "R5" : "R3", h, in_win(8'(a)));
    end

    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = lf[9] ? (lf[8] ? {3'b100, lf[4:0]} : {3'b001, lf[4:0]}) : lf[7:0];
      cyc(a, lf[10] & lf[11], lf[13:12], lf[15:8] ^ 8'(i), h);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule